// File: doc/BRIEF.md
# Polled Memory-Mapped Byte Port

This block is a slave on a simple processor load/store bus. It claims a fixed high address window, the top 64 KiB of a 32-bit space, where no memory exists. Inside that window it exposes two channels, one for receive and one for transmit. Each channel has a control/status word and a byte-wide data word.

On the device side, incoming bytes arrive over a valid/ready stream and outgoing bytes leave over a second valid/ready stream. Software polls a channel's ready bit in its control word. When the bit is set, software loads from the receive data word or stores to the transmit data word. That access clears the ready bit with no further action. Each channel also has an interrupt-enable bit, and the single interrupt pin reflects the channels that are both ready and enabled.

Back-pressure rules: the receive stream offers `in_ready` while the receive byte slot is empty. It also offers it in any cycle in which the processor is loading the receive data word, so a new byte can replace the one being read. A byte is taken on a cycle where `in_valid` and `in_ready` are both high. The transmit stream holds `out_valid` and `out_data` steady until the device raises `out_ready`. The byte is consumed on the cycle where both are high.

Top module: `mmio_poll_port`

## Requirements
- R1: `bus_sel` is high exactly when `bus_valid` is high and `bus_addr[31:16]` equals 16'hFFFF. An access outside that window has no effect on any register and produces no `bus_rvalid`.
- R2: On the receive stream, `in_ready` is high while the receive slot is empty, or while a receive-data load is in progress in the same cycle. An accepted byte is stored and sets the receive ready bit, which is bit 0 of the word at offset 0x0. A full slot is never overwritten by the device unless it is being read.
- R3: A load from offset 0x4 returns the stored byte in bits [7:0], with zeros in bits [31:8]. When the slot was full, the load clears the receive ready bit.
- R4: A load from either control word (offset 0x0 or 0x8) changes no state.
- R5: When a byte is accepted in the same cycle as a receive-data load, the set wins. After that cycle the ready bit is 1 and the slot holds the new byte. The load itself returns the old byte.
- R6: A store to offset 0xC while the transmit ready bit (bit 0 of offset 0x8) is 1 loads bits [7:0] into the slot. It clears that ready bit and raises `out_valid`. A store to 0xC while the ready bit is 0 is ignored.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. A handshake drops `out_valid` on the next cycle and sets the transmit ready bit.
- R8: Bit 1 of each control word is a read/write interrupt enable. Both enables reset to 0. A write to bit 0 of a control word has no effect.
- R9: `irq` equals (receive ready AND receive enable) OR (transmit ready AND transmit enable).
- R10: Inside the window, any offset other than 0x0, 0x4, 0x8 and 0xC reads as zero, and a write to such an offset is ignored. Bits [1:0] of the address are not decoded.
- R11: After reset the receive ready bit is 0, the transmit ready bit is 1, both enables are 0, and `irq` and `out_valid` are low.
- R12: A window load raises `bus_rvalid` for one cycle, in the cycle after the request. `bus_rdata` carries the value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_write | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_sel | output | 1 | Request falls in the device window |
| bus_rvalid | output | 1 | Load data valid, one cycle after the request |
| bus_rdata | output | 32 | Load data |
| in_valid | input | 1 | Device offers a received byte |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Port can take the received byte |
| out_valid | output | 1 | Port offers a byte for transmission |
| out_ready | input | 1 | Device takes the offered byte |
| out_data | output | 8 | Byte for transmission |
| irq | output | 1 | Interrupt request |

## Verification
`bus_sel` and `in_ready` are combinational, so the bench checks them one time step after it drives the request, inside the same cycle. Load data and `bus_rvalid` become valid one edge after the request. Ready bits, `out_valid`, `out_data` and `irq` change on the edge that ends the access or handshake. The bench drives every operation on a falling edge and samples all of these results on the next falling edge. It then checks them against a reference model that it updates only after that edge.

// File: rtl/mmio_poll_pkg.sv
package mmio_poll_pkg;
  // Register selector inside the device window (word offset bits [3:2])
  typedef enum logic [1:0] {
    SEL_RX_CTRL = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_CTRL = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;     // address is inside the window
    logic     mapped;  // offset names one of the four words
    reg_sel_e sel;
  } decode_t;

  localparam int CTRL_READY_BIT = 0;
  localparam int CTRL_IE_BIT    = 1;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = '1
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);
  localparam int REG_BITS = 4;  // four 32-bit words
  localparam int HI_BITS  = WIN_BITS - REG_BITS;

  logic [HI_BITS-1:0] hi_off;
  assign hi_off = addr[WIN_BITS-1:REG_BITS];

  always_comb begin
    dec.hit    = req && (addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
    dec.mapped = (hi_off == '0);
    dec.sel    = reg_sel_e'(addr[REG_BITS-1:2]);
  end
endmodule

// File: rtl/mmio_rx_channel.sv
module mmio_rx_channel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              rd_data_stb,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  output logic              full,
  output logic              ie,
  output logic [DATA_W-1:0] data
);
  logic take;

  assign in_ready = !full || rd_data_stb;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      ie   <= 1'b0;
      data <= '0;
    end else begin
      if (take) begin
        full <= 1'b1;          // set wins over the read clear
        data <= in_data;
      end else if (rd_data_stb) begin
        full <= 1'b0;
      end
      if (ie_wr) ie <= ie_wdata;
    end
  end

  // R3: a data load of a full slot with no new byte empties it
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && full && !in_valid) |=> !full);
  // R5: an accepted byte is always held afterwards, even during a read
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (full && data == $past(in_data)));
  // R2: a full slot that is not being read keeps its byte
  p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_data_stb) |=> (full && $stable(data)));
endmodule

// File: rtl/mmio_tx_channel.sv
module mmio_tx_channel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              space,
  output logic              ie
);
  logic full;
  logic load;

  assign load      = wr_stb && !full;
  assign out_valid = full;
  assign space     = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
      ie       <= 1'b0;
    end else begin
      if (load) begin
        full     <= 1'b1;
        out_data <= wr_data;
      end else if (full && out_ready) begin
        full <= 1'b0;
      end
      if (ie_wr) ie <= ie_wdata;
    end
  end

  // R6: a store into an empty slot is offered to the device
  p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && space) |=> (out_valid && out_data == $past(wr_data)));
  // R7: offered byte holds until taken
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R7: a handshake frees the slot
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> space);
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BUS_W    = 32,
  parameter int DATA_W   = 8,
  parameter int WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_sel,
  output logic              bus_rvalid,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              irq
);
  localparam int PAD_W = BUS_W - DATA_W;

  decode_t dec;
  logic acc_rd, acc_wr;
  logic rx_data_rd, rx_ctrl_wr, tx_data_wr, tx_ctrl_wr;
  logic rx_full, rx_ie, tx_space, tx_ie;
  logic [DATA_W-1:0] rx_byte;
  logic [BUS_W-1:0]  rd_mux;

  mmio_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_dec (
    .req(bus_valid), .addr(bus_addr), .dec(dec)
  );

  assign bus_sel = dec.hit;
  assign acc_rd  = dec.hit && dec.mapped && !bus_write;
  assign acc_wr  = dec.hit && dec.mapped && bus_write;

  assign rx_data_rd = acc_rd && (dec.sel == SEL_RX_DATA);
  assign rx_ctrl_wr = acc_wr && (dec.sel == SEL_RX_CTRL);
  assign tx_data_wr = acc_wr && (dec.sel == SEL_TX_DATA);
  assign tx_ctrl_wr = acc_wr && (dec.sel == SEL_TX_CTRL);

  mmio_rx_channel #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_data_stb(rx_data_rd),
    .ie_wr(rx_ctrl_wr), .ie_wdata(bus_wdata[CTRL_IE_BIT]),
    .full(rx_full), .ie(rx_ie), .data(rx_byte)
  );

  mmio_tx_channel #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(tx_data_wr), .wr_data(bus_wdata[DATA_W-1:0]),
    .ie_wr(tx_ctrl_wr), .ie_wdata(bus_wdata[CTRL_IE_BIT]),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .space(tx_space), .ie(tx_ie)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.mapped) begin
      unique case (dec.sel)
        SEL_RX_CTRL: begin
          rd_mux[CTRL_READY_BIT] = rx_full;
          rd_mux[CTRL_IE_BIT]    = rx_ie;
        end
        SEL_RX_DATA: rd_mux = {{PAD_W{1'b0}}, rx_byte};
        SEL_TX_CTRL: begin
          rd_mux[CTRL_READY_BIT] = tx_space;
          rd_mux[CTRL_IE_BIT]    = tx_ie;
        end
        SEL_TX_DATA: rd_mux = '0;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= dec.hit && !bus_write;
      if (dec.hit && !bus_write) bus_rdata <= rd_mux;
    end
  end

  assign irq = (rx_full && rx_ie) || (tx_space && tx_ie);

  // R12: every window load is answered on the next cycle
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write) |=> bus_rvalid);
  // R10: unmapped window offsets read as zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write && !dec.mapped) |=> (bus_rdata == '0));
  // R1: no response to loads outside the window
  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel) |=> !bus_rvalid);
  // R4: a control load leaves the receive slot untouched
  p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && dec.sel == SEL_RX_CTRL && !in_valid) |=> $stable(rx_full));
endmodule

// File: tb/mmio_poll_port_tb.sv
`timescale 1ns/100ps
module mmio_poll_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic bus_sel, bus_rvalid;
  logic [31:0] bus_rdata;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic irq;

  always #2.5 clk = ~clk;

  mmio_poll_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_sel(bus_sel), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // reference model
  bit m_rx_full, m_tx_full, m_rx_ie, m_tx_ie;
  logic [7:0] m_rx_byte, m_tx_byte;

  localparam logic [31:0] BASE = 32'hFFFF_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    logic [31:0] v = '0;
    if (a[15:4] != 0) return '0;                   // R10
    case (a[3:2])
      2'd0: v = {30'd0, m_rx_ie, m_rx_full};
      2'd1: v = {24'd0, m_rx_byte};
      2'd2: v = {30'd0, m_tx_ie, !m_tx_full};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_irq();
    return (m_rx_full && m_rx_ie) || (!m_tx_full && m_tx_ie);
  endfunction

  task automatic check_outputs(input string tag);
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
    check({tag, " R7 out_valid"}, {31'd0, out_valid}, {31'd0, m_tx_full});
    if (m_tx_full) check({tag, " R7 out_data"}, {24'd0, out_data}, {24'd0, m_tx_byte});
  endtask

  // one bus access; returns bus_sel during the request and the response
  task automatic bus_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic push, input logic [7:0] pb,
                        output logic sel, output logic rv, output logic [31:0] rd,
                        output logic inr);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    in_valid = push; in_data = pb;
    #1; sel = bus_sel; inr = in_ready;
    @(negedge clk);
    bus_valid = 1'b0; in_valid = 1'b0;
    rv = bus_rvalid; rd = bus_rdata;
  endtask

  // model update for a window access that hit the window
  task automatic model_access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                              input logic accepted, input logic [7:0] pb);
    bit mapped = (a[15:4] == 0);
    if (mapped && wr) begin
      case (a[3:2])
        2'd0: m_rx_ie = d[1];
        2'd2: m_tx_ie = d[1];
        2'd3: if (!m_tx_full) begin m_tx_full = 1; m_tx_byte = d[7:0]; end
        default: ;
      endcase
    end
    if (mapped && !wr && a[3:2] == 2'd1) m_rx_full = 0;
    if (accepted) begin m_rx_full = 1; m_rx_byte = pb; end
  endtask

  task automatic do_read(input string req, input logic [31:0] a);
    logic s, rv, inr; logic [31:0] rd, e;
    e = exp_read(a);
    bus_op(1'b0, a, 32'd0, 1'b0, 8'd0, s, rv, rd, inr);
    check({req, " R12 rvalid"}, {31'd0, rv}, 32'd1);
    check({req, " read data"}, rd, e);
    model_access(1'b0, a, 32'd0, 1'b0, 8'd0);
    check_outputs(req);
  endtask

  task automatic do_write(input string req, input logic [31:0] a, input logic [31:0] d);
    logic s, rv, inr; logic [31:0] rd;
    bus_op(1'b1, a, d, 1'b0, 8'd0, s, rv, rd, inr);
    check({req, " R1 sel"}, {31'd0, s}, 32'd1);
    model_access(1'b1, a, d, 1'b0, 8'd0);
    check_outputs(req);
  endtask

  task automatic dev_push(input logic [7:0] b);
    logic inr;
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    #1; inr = in_ready;
    check("R2 in_ready", {31'd0, inr}, {31'd0, !m_rx_full});
    @(negedge clk);
    in_valid = 1'b0;
    if (!m_rx_full) begin m_rx_full = 1; m_rx_byte = b; end
    check_outputs("R2 push");
  endtask

  task automatic dev_take();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    if (m_tx_full) m_tx_full = 0;
    check_outputs("R7 take");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic s, rv, inr; logic [31:0] rd;
    int unused;
    unused = $urandom(32'd1234);
    m_rx_full = 0; m_tx_full = 0; m_rx_ie = 0; m_tx_ie = 0;
    m_rx_byte = 0; m_tx_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 irq", {31'd0, irq}, 32'd0);
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    do_read("R11 rx ctrl", BASE + 32'h0);
    do_read("R11 tx ctrl", BASE + 32'h8);

    // R2/R3 receive path and R4 ctrl polling without side effects
    dev_push(8'hA5);
    do_read("R4 poll1", BASE + 32'h0);
    do_read("R4 poll2", BASE + 32'h0);
    dev_push(8'h11);                               // full: refused
    do_read("R3 data", BASE + 32'h4);
    do_read("R3 ready clear", BASE + 32'h0);

    // R5 set wins: push during data load
    dev_push(8'h3C);
    bus_op(1'b0, BASE + 32'h4, 32'd0, 1'b1, 8'hC3, s, rv, rd, inr);
    check("R5 in_ready during read", {31'd0, inr}, 32'd1);
    check("R5 old byte returned", rd, 32'h3C);
    model_access(1'b0, BASE + 32'h4, 32'd0, 1'b1, 8'hC3);
    do_read("R5 ready kept", BASE + 32'h0);
    do_read("R5 new byte", BASE + 32'h4);

    // R6/R7 transmit path
    do_write("R6 store", BASE + 32'hC, 32'hFFFF_FF5A);
    do_read("R6 ready clear", BASE + 32'h8);
    do_write("R6 store ignored", BASE + 32'hC, 32'h0000_0077);
    repeat (3) @(negedge clk);
    check_outputs("R7 hold");
    dev_take();
    do_read("R7 ready set", BASE + 32'h8);

    // R8/R9 enables
    do_write("R8 rx ie", BASE + 32'h0, 32'h3);
    do_write("R8 tx ie", BASE + 32'h8, 32'h2);
    do_read("R8 rx ctrl", BASE + 32'h0);
    do_write("R9 tx ie off", BASE + 32'h8, 32'h0);
    dev_push(8'h42);
    do_read("R9 rx data", BASE + 32'h4);

    // R10 unmapped offsets
    do_write("R10 unmapped write", BASE + 32'h10, 32'hFFFF_FFFF);
    do_read("R10 unmapped read", BASE + 32'h10);
    do_read("R10 unmapped read hi", BASE + 32'h8004);

    // R1 outside the window
    bus_op(1'b1, 32'hFFFE_000C, 32'h99, 1'b0, 8'd0, s, rv, rd, inr);
    check("R1 outside sel", {31'd0, s}, 32'd0);
    check_outputs("R1 outside write");
    bus_op(1'b0, 32'h0000_0004, 32'd0, 1'b0, 8'd0, s, rv, rd, inr);
    check("R1 outside rvalid", {31'd0, rv}, 32'd0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] a = BASE + {$urandom_range(0, 4), 2'b00};
      logic [31:0] d = $urandom;
      case (op)
        0: dev_push(8'($urandom));
        1: dev_take();
        2, 3: do_read("R3 rand read", a);
        default: begin
          if (a[3:2] == 2'd0 || a[3:2] == 2'd2) d[0] = $urandom_range(0, 1);
          do_write("R6 rand write", a, d);
        end
      endcase
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule